// File: doc/BRIEF.md
# Memory Window Address Translator

This block sits between the system request path and a memory-channel controller. It takes a 26-bit physical address and turns it into a 36-bit channel address and a broadcast flag. It then looks the result up in a small table of attached memory devices and reports which device answers, the address inside that device, and whether the access goes to memory space, to the registers of one device, or to the registers of every device.

Requests arrive with a valid/ready handshake. Each accepted request produces exactly one registered result one cycle later, and results leave in request order. Software fills the device table through a write-only configuration port. Each entry holds an enable bit, a 9-bit identifier and a double-bank flag. When a double-bank device is matched, the lowest identifier bit is ignored, so one entry covers two consecutive 1 MiB rows. The address space has three windows. Addresses below 0x3F00000 are memory space. The range 0x3F00000 to 0x3F7FFFF is single-device register space. The range 0x3F80000 to 0x3FFFFFF is broadcast register space.

Top module: `addr_xlate`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1 and every table entry is disabled, so no unicast request matches a device.
- R2: For an address below 0x3F00000, chan[28:20] equals address bits 25:20 zero-extended, chan[19:0] equals address bits 19:0, rsp_kind is 0 (memory) and rsp_bcast is 0.
- R3: For an address at or above 0x3F00000, both chan[28:20] and chan[19:11] hold address bits 18:10, and chan[10:0] holds address bits 9:0 with bit 10 zero. On a device hit, rsp_offset is chan[10:0] zero-extended.
- R4: In register space, rsp_bcast equals address bit 19, and rsp_kind is 1 (one device's registers) when that bit is 0 and 2 (all devices' registers) when it is 1.
- R5: chan[35:29] is always zero.
- R6: A unicast request hits an enabled entry whose identifier equals chan[28:20]. For a double-bank entry, identifier bit 0 is left out of the comparison. On a memory hit, rsp_offset is chan[20:0] for a double-bank device and chan[19:0] zero-extended for a single-bank device.
- R7: A broadcast write is forwarded with rsp_err 0, rsp_dev 0 and rsp_offset equal to chan[10:0]. A broadcast read has rsp_err set to 1.
- R8: A memory or single-device register request that matches no enabled entry has rsp_err set to 1. Every errored result carries rsp_dev 0 and rsp_offset 0.
- R9: When several enabled entries match, the entry with the lowest index answers.
- R10: A request accepted on one clock edge has its result on rsp_valid after that edge. With rsp_ready held at 1, one request is accepted on every cycle.
- R11: While rsp_valid is 1 and rsp_ready is 0, req_ready is 0 and every result output stays unchanged.
- R12: A configuration write takes effect for requests accepted on later edges. A request accepted on the same edge as the write is looked up in the table as it was before the write. A disabled entry never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 26 | System physical address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | DEV_W | Entry index to write |
| cfg_id | input | 9 | Device identifier |
| cfg_dbl | input | 1 | Entry is a double-bank device |
| cfg_en | input | 1 | Entry enabled |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_chan_addr | output | 36 | Translated channel address |
| rsp_kind | output | 2 | 0 memory, 1 one device's registers, 2 all devices' registers |
| rsp_bcast | output | 1 | Broadcast-register flag |
| rsp_write | output | 1 | Direction carried from the request |
| rsp_dev | output | DEV_W | Answering device index |
| rsp_offset | output | 21 | Address inside the device |
| rsp_err | output | 1 | Request not forwarded |

## Verification
A configuration write and a request acceptance can happen on the same clock edge. The question in that case is whether the lookup uses the old table or the new one. The bench forces the collision by driving cfg_we and req_valid together while the output is free. The first request then expects the pre-write outcome, a miss, and an identical request sent right after it expects the newly written device. Output stalls and request acceptance also overlap: random back-pressure on rsp_ready checks that results held during a stall stay frozen while the scoreboard keeps its order.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;
   localparam int SYS_AW    = 26;
   localparam int CH_AW     = 36;
   localparam int ID_W      = 9;
   localparam int OFS_W     = 21;
   localparam int REG_OFS_W = 11;
   localparam logic [SYS_AW-1:0] REG_BASE = 26'h3F0_0000;

   typedef enum logic [1:0] {
      KIND_MEM   = 2'd0,
      KIND_REG   = 2'd1,
      KIND_BCAST = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/addr_xlate_win.sv
module addr_xlate_win
   import addr_xlate_pkg::*;
(
   input  logic [SYS_AW-1:0] sys_addr,
   output logic [CH_AW-1:0]  chan,
   output acc_kind_e         kind,
   output logic              bcast
);
   logic [ID_W-1:0] reg_fld;

   assign reg_fld = sys_addr[18:10];

   always_comb begin
      chan  = '0;
      kind  = KIND_MEM;
      bcast = 1'b0;
      if (sys_addr < REG_BASE) begin
         chan[28:20] = {3'b000, sys_addr[25:20]};
         chan[19:0]  = sys_addr[19:0];
      end else begin
         chan[28:20] = reg_fld;
         chan[19:11] = reg_fld;
         chan[10:0]  = {1'b0, sys_addr[9:0]};
         bcast       = sys_addr[19];
         kind        = sys_addr[19] ? KIND_BCAST : KIND_REG;
      end
   end
endmodule

// File: rtl/addr_xlate_devtab.sv
module addr_xlate_devtab
   import addr_xlate_pkg::*;
#(
   parameter int NUM_DEV = 8,
   parameter int DEV_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [DEV_W-1:0] cfg_idx,
   input  logic [ID_W-1:0]  cfg_id,
   input  logic             cfg_dbl,
   input  logic             cfg_en,
   input  logic [ID_W-1:0]  look_id,
   output logic             hit,
   output logic [DEV_W-1:0] hit_idx,
   output logic             hit_dbl
);
   logic [NUM_DEV-1:0] hit_vec;
   logic [NUM_DEV-1:0] dbl_vec;

   for (genvar g = 0; g < NUM_DEV; g++) begin : g_ent
      logic            en_q;
      logic            dbl_q;
      logic [ID_W-1:0] id_q;
      logic [ID_W-1:0] mask;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q  <= 1'b0;
            dbl_q <= 1'b0;
            id_q  <= '0;
         end else if (cfg_we && cfg_idx == DEV_W'(g)) begin
            en_q  <= cfg_en;
            dbl_q <= cfg_dbl;
            id_q  <= cfg_id;
         end
      end

      assign mask       = dbl_q ? {{(ID_W-1){1'b1}}, 1'b0} : {ID_W{1'b1}};
      assign hit_vec[g] = en_q && (((id_q ^ look_id) & mask) == '0);
      assign dbl_vec[g] = dbl_q;
   end

   always_comb begin
      hit_idx = '0;
      hit_dbl = 1'b0;
      for (int i = NUM_DEV - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            hit_idx = DEV_W'(i);
            hit_dbl = dbl_vec[i];
         end
      end
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
   import addr_xlate_pkg::*;
#(
   parameter  int NUM_DEV = 8,
   localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SYS_AW-1:0] req_addr,
   input  logic              req_write,
   input  logic              cfg_we,
   input  logic [DEV_W-1:0]  cfg_idx,
   input  logic [ID_W-1:0]   cfg_id,
   input  logic              cfg_dbl,
   input  logic              cfg_en,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [CH_AW-1:0]  rsp_chan_addr,
   output logic [1:0]        rsp_kind,
   output logic              rsp_bcast,
   output logic              rsp_write,
   output logic [DEV_W-1:0]  rsp_dev,
   output logic [OFS_W-1:0]  rsp_offset,
   output logic              rsp_err
);
   if (NUM_DEV < 1 || NUM_DEV > 32) begin : g_bad_num
      $error("addr_xlate: NUM_DEV must lie in 1..32");
   end

   logic [CH_AW-1:0] chan;
   acc_kind_e        kind;
   logic             bcast;
   logic             hit;
   logic [DEV_W-1:0] hit_idx;
   logic             hit_dbl;
   logic             nxt_err;
   logic [DEV_W-1:0] nxt_dev;
   logic [OFS_W-1:0] nxt_ofs;
   logic             take;

   addr_xlate_win u_win (
      .sys_addr (req_addr),
      .chan     (chan),
      .kind     (kind),
      .bcast    (bcast)
   );

   addr_xlate_devtab #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_we),
      .cfg_idx (cfg_idx),
      .cfg_id  (cfg_id),
      .cfg_dbl (cfg_dbl),
      .cfg_en  (cfg_en),
      .look_id (chan[28:20]),
      .hit     (hit),
      .hit_idx (hit_idx),
      .hit_dbl (hit_dbl)
   );

   always_comb begin
      nxt_err = bcast ? !req_write : !hit;
      nxt_dev = '0;
      nxt_ofs = '0;
      if (!nxt_err) begin
         if (bcast) begin
            nxt_ofs = {{(OFS_W-REG_OFS_W){1'b0}}, chan[10:0]};
         end else begin
            nxt_dev = hit_idx;
            if (kind == KIND_MEM)
               nxt_ofs = hit_dbl ? chan[20:0] : {1'b0, chan[19:0]};
            else
               nxt_ofs = {{(OFS_W-REG_OFS_W){1'b0}}, chan[10:0]};
         end
      end
   end

   assign req_ready = !rsp_valid || rsp_ready;
   assign take      = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_chan_addr <= '0;
         rsp_kind      <= KIND_MEM;
         rsp_bcast     <= 1'b0;
         rsp_write     <= 1'b0;
         rsp_dev       <= '0;
         rsp_offset    <= '0;
         rsp_err       <= 1'b0;
      end else begin
         if (take) begin
            rsp_valid     <= 1'b1;
            rsp_chan_addr <= chan;
            rsp_kind      <= kind;
            rsp_bcast     <= bcast;
            rsp_write     <= req_write;
            rsp_dev       <= nxt_dev;
            rsp_offset    <= nxt_ofs;
            rsp_err       <= nxt_err;
         end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/addr_xlate_chk.sv
module addr_xlate_chk #(
   parameter int DEV_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [35:0]       rsp_chan_addr,
   input logic [1:0]        rsp_kind,
   input logic              rsp_bcast,
   input logic              rsp_write,
   input logic [DEV_W-1:0]  rsp_dev,
   input logic [20:0]       rsp_offset,
   input logic              rsp_err
);
   p_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_chan_addr[35:29] == 7'd0);

   p_dup_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind != 2'd0) |-> rsp_chan_addr[28:20] == rsp_chan_addr[19:11]);

   p_mem_nobc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == 2'd0) |-> !rsp_bcast);

   p_kind_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_bcast == (rsp_kind == 2'd2)));

   p_bc_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_bcast && !rsp_err) |-> rsp_write);

   p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_dev == '0 && rsp_offset == 21'd0));

   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   p_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_chan_addr) && $stable(rsp_dev)
                                     && $stable(rsp_offset) && $stable(rsp_err)));
endmodule

bind addr_xlate addr_xlate_chk #(.DEV_W(DEV_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_ready     (rsp_ready),
   .rsp_chan_addr (rsp_chan_addr),
   .rsp_kind      (rsp_kind),
   .rsp_bcast     (rsp_bcast),
   .rsp_write     (rsp_write),
   .rsp_dev       (rsp_dev),
   .rsp_offset    (rsp_offset),
   .rsp_err       (rsp_err)
);

// File: tb/tb_addr_xlate.sv
module tb_addr_xlate;
   localparam int CLK_PERIOD = 10;
   localparam int NDEV = 8;
   localparam int DW = 3;

   typedef struct {
      logic [35:0] chan;
      logic [1:0]  kind;
      logic        bcast;
      logic        wr;
      logic [DW-1:0] dev;
      logic [20:0] ofs;
      logic        err;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [25:0] req_addr = '0;
   logic req_write = 1'b0;
   logic cfg_we = 1'b0;
   logic [DW-1:0] cfg_idx = '0;
   logic [8:0] cfg_id = '0;
   logic cfg_dbl = 1'b0;
   logic cfg_en = 1'b0;
   logic rsp_valid;
   logic rsp_ready = 1'b1;
   logic [35:0] rsp_chan_addr;
   logic [1:0] rsp_kind;
   logic rsp_bcast;
   logic rsp_write;
   logic [DW-1:0] rsp_dev;
   logic [20:0] rsp_offset;
   logic rsp_err;

   int n_chk = 0;
   int n_bad = 0;
   exp_t q[$];
   bit stall = 0;
   bit just_acc = 0;
   bit done = 0;

   logic       m_en [NDEV];
   logic       m_dbl[NDEV];
   logic [8:0] m_id [NDEV];

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_xlate #(.NUM_DEV(NDEV)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_id(cfg_id), .cfg_dbl(cfg_dbl), .cfg_en(cfg_en),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_chan_addr(rsp_chan_addr),
      .rsp_kind(rsp_kind), .rsp_bcast(rsp_bcast), .rsp_write(rsp_write),
      .rsp_dev(rsp_dev), .rsp_offset(rsp_offset), .rsp_err(rsp_err)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [25:0] a, input logic wr, input string tag);
      exp_t e;
      logic [8:0] f;
      logic [8:0] idv;
      bit hit;
      e.tag = tag; e.wr = wr; e.dev = '0; e.ofs = '0; e.bcast = 0; e.err = 0;
      if (a < 26'h3F00000) begin
         e.chan = (36'(a >> 20) & 36'h3F) << 20 | (36'(a) & 36'hFFFFF);
         e.kind = 2'd0;
      end else begin
         f = 9'((a >> 10) & 26'h1FF);
         e.chan = (36'(f) << 20) | (36'(f) << 11) | (36'(a) & 36'h3FF);
         e.bcast = a[19];
         e.kind = a[19] ? 2'd2 : 2'd1;
      end
      idv = e.chan[28:20];
      if (e.bcast) begin
         e.err = !wr;
         if (wr) e.ofs = {10'd0, e.chan[10:0]};
      end else begin
         hit = 0;
         for (int i = 0; i < NDEV; i++) begin
            if (!hit && m_en[i] && ((m_id[i] ^ idv) & (m_dbl[i] ? 9'h1FE : 9'h1FF)) == 9'd0) begin
               hit = 1;
               e.dev = DW'(i);
               if (e.kind == 2'd0) e.ofs = m_dbl[i] ? e.chan[20:0] : {1'b0, e.chan[19:0]};
               else e.ofs = {10'd0, e.chan[10:0]};
            end
         end
         e.err = !hit;
      end
      return e;
   endfunction

   task automatic send_cfg(input logic [25:0] a, input logic wr, input string tag,
                           input bit do_cfg, input int idx, input logic [8:0] id,
                           input logic dbl, input logic en);
      exp_t e;
      bit acc;
      bit cfg_pending = do_cfg;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr;
      if (do_cfg) begin
         cfg_we = 1'b1; cfg_idx = DW'(idx); cfg_id = id; cfg_dbl = dbl; cfg_en = en;
      end
      forever begin
         #1;
         e = model(a, wr, tag);
         acc = req_ready;
         @(posedge clk);
         #1;
         if (cfg_pending) begin
            m_en[idx] = en; m_dbl[idx] = dbl; m_id[idx] = id;
            cfg_we = 1'b0; cfg_pending = 0;
         end
         if (acc) begin
            q.push_back(e);
            just_acc = 1;
            req_valid = 1'b0;
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic send(input logic [25:0] a, input logic wr, input string tag);
      send_cfg(a, wr, tag, 0, 0, 9'd0, 1'b0, 1'b0);
   endtask

   task automatic cfg(input int idx, input logic [8:0] id, input logic dbl, input logic en);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = DW'(idx); cfg_id = id; cfg_dbl = dbl; cfg_en = en;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      m_en[idx] = en; m_dbl[idx] = dbl; m_id[idx] = id;
   endtask

   // monitor and scoreboard
   initial begin
      exp_t e;
      bit held = 0;
      logic [35:0] h_chan;
      logic [20:0] h_ofs;
      logic [DW-1:0] h_dev;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (held) begin
               check(rsp_valid && rsp_chan_addr == h_chan && rsp_offset == h_ofs && rsp_dev == h_dev,
                     "R11", "held result", 64'(rsp_chan_addr), 64'(h_chan));
               held = 0;
            end
            if (just_acc) begin
               check(rsp_valid, "R10", "valid after accept", 64'(rsp_valid), 64'd1);
               just_acc = 0;
            end
            rsp_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
            #0;
            if (rsp_valid && !rsp_ready) begin
               held = 1; h_chan = rsp_chan_addr; h_ofs = rsp_offset; h_dev = rsp_dev;
               #0;
               check(!req_ready, "R11", "req_ready during stall", 64'(req_ready), 64'd0);
            end
            if (rsp_valid && rsp_ready) begin
               if (q.size() == 0) begin
                  check(0, "R10", "unexpected result", 64'(rsp_chan_addr), 64'd0);
               end else begin
                  e = q.pop_front();
                  check(rsp_chan_addr == e.chan, e.tag, "chan", 64'(rsp_chan_addr), 64'(e.chan));
                  check(rsp_kind == e.kind && rsp_bcast == e.bcast && rsp_write == e.wr,
                        e.tag, "kind/bcast/write", {59'd0, rsp_kind, rsp_bcast, rsp_write},
                        {59'd0, e.kind, e.bcast, e.wr});
                  check(rsp_dev == e.dev && rsp_offset == e.ofs && rsp_err == e.err,
                        e.tag, "dev/ofs/err", {32'(rsp_dev), 11'd0, rsp_offset[19:0], rsp_err},
                        {32'(e.dev), 11'd0, e.ofs[19:0], e.err});
                  check(rsp_offset[20] == e.ofs[20], e.tag, "offset bit 20",
                        64'(rsp_offset[20]), 64'(e.ofs[20]));
               end
            end
         end
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < NDEV; i++) begin
         m_en[i] = 0; m_dbl[i] = 0; m_id[i] = '0;
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
      check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);

      // empty table: unicast miss
      send(26'h0000100, 1'b0, "R1");
      send(26'h3F00808, 1'b1, "R1");

      // four double-bank devices with IDs 0,2,4,6
      for (int i = 0; i < 4; i++) cfg(i, 9'(2 * i), 1'b1, 1'b1);
      send(26'h003ABCD, 1'b0, "R2");
      send(26'h03ABCDE, 1'b0, "R6");
      send(26'h3F00808, 1'b1, "R3");
      send(26'h3F80008, 1'b1, "R7");
      send(26'h3F80008, 1'b0, "R7");
      send(26'h3FABCDE, 1'b1, "R4");
      send(26'h0800000, 1'b0, "R8");
      send(26'h3EFFFFF, 1'b1, "R5");
      send(26'h3F7FFFF, 1'b0, "R8");

      // single-bank device with ID 8
      cfg(4, 9'd8, 1'b0, 1'b1);
      send(26'h0812345, 1'b0, "R6");
      send(26'h0912345, 1'b0, "R6");
      cfg(5, 9'd8, 1'b1, 1'b1);
      send(26'h0800040, 1'b1, "R9");
      send(26'h0900040, 1'b1, "R9");
      cfg(4, 9'd8, 1'b0, 1'b0);
      send(26'h0800040, 1'b1, "R12");

      // configuration write and request on the same edge
      send_cfg(26'h0A00010, 1'b0, "R12", 1, 6, 9'd10, 1'b0, 1'b1);
      send(26'h0A00010, 1'b0, "R12");

      // back-to-back without stall
      for (int i = 0; i < 20; i++) send(26'($urandom) & 26'h3FFFFFF, 1'($urandom), "R10");

      // random traffic under back-pressure
      stall = 1;
      for (int i = 0; i < 300; i++) begin
         logic [25:0] a;
         a = (i % 3 == 0) ? (26'h3F00000 | 26'($urandom_range(0, 26'hFFFFF)))
                          : 26'($urandom_range(0, 26'h0BFFFFF));
         send(a, 1'($urandom), "R11");
      end
      stall = 0;
      repeat (20) @(posedge clk);
      check(q.size() == 0, "R10", "results left over", 64'(q.size()), 64'd0);
      done = 1;
      finish_run();
   end
endmodule